// File: doc/BRIEF.md
# Packet-Walking OTP Read Controller

This block is a register-mapped read engine for a one-time-programmable word array. The array holds back-to-back packets. Each packet is one header word and then a payload whose length is encoded in that header. Software writes a word address into the mode register and sets the start bit in the control register. The controller then walks the headers from word 0 until it reaches the packet whose word range holds that address. It copies the header and the whole payload into local buffers and drops its busy flag.

The returned packet is always the enclosing one, read from its header onward, and never the single word at the requested address. Software reads the header from one register. It pulls payload words in order from a data register, and a writable payload index selects where that stream starts. The array itself sits outside the block. It is read through a synchronous port with one cycle of latency.

Top module: `otpPacketReader`

## Requirements
- R1: After reset, the status (0x0C), header (0x20), mode (0x04) and payload index (0x08) registers all read 0.
- R2: The mode register at 0x04 keeps the requested word address in bits 31:16, and bits 15:0 read back as 0. A write to 0x00 with bit 6 set issues a read command. The control register always reads as 0.
- R3: Status bit 6 (busy) rises on the clock edge that accepts a command. It never rises without an accepted command.
- R4: Header bits 15:8 hold a size field S, and the packet takes S+2 words (header plus S+1 payload words). The first packet starts at word 0 and each next one starts directly after the previous packet. The walk reads word 0 first.
- R5: A command for any word address in [packet start, next packet start) returns that packet. After completion, the header register (0x20) equals that packet's header word.
- R6: Writing N to the payload index register (0x08) makes the next read of the data register (0x24) return payload word N, with word 0 following the header. Each data read advances the index by one.
- R7: A data read with the index beyond the last payload word (index > S) returns 0.
- R8: Status bit 0 (error) is set when the walk meets a header with S = 0, or a packet that would run past the end of the array, before reaching the address. Busy then drops. Error stays 0 while busy and is cleared by the next accepted command.
- R9: A read command issued while busy is ignored. The packet returned and the busy duration are unchanged.
- R10: With h headers visited, busy lasts 2h+S+2 cycles on success and 2h cycles on error.
- R11: Array reads occur only while busy, at word addresses below the array depth. Data returns one cycle after the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 6 | Register byte offset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (advances the payload index on 0x24) |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| romEn | output | 1 | Array read enable |
| romAddr | output | 12 | Array word address |
| romData | input | 32 | Array read data, valid the cycle after romEn |

## Verification
The bench first targets the edges of each packet: its header word, its last payload word and the first word of the next packet. A design with an off-by-one in the range compare would return a neighbouring packet there. Reading one word past a payload, and using the largest size field, catch a buffer that wraps or leaks stale words. Addressing the terminating zero header shows whether the error path sets the flag and ends cleanly rather than walking on. A command injected mid-walk is compared cycle by cycle against the expected busy window, so a design that restarts or extends the walk is caught.

// File: rtl/otpPktPkg.sv
package otpPktPkg;
  localparam int SIZE_W  = 8;
  localparam int PAY_MAX = 1 << SIZE_W;
  localparam int IDX_W   = SIZE_W + 1;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_MODE = 6'h04;
  localparam logic [5:0] OFS_AUX  = 6'h08;
  localparam logic [5:0] OFS_STAT = 6'h0C;
  localparam logic [5:0] OFS_HDR  = 6'h20;
  localparam logic [5:0] OFS_DATA = 6'h24;

  localparam int START_BIT = 6;
  localparam int BUSY_BIT  = 6;
  localparam int ERR_BIT   = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CHK, ST_PAY, ST_LAST
  } walkState_t;

  typedef struct packed {
    logic             busy;
    logic             err;
    logic             hdrLoad;
    logic             bufWr;
    logic [IDX_W-1:0] bufIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/otpPktCtrl.sv
module otpPktCtrl
  import otpPktPkg::*;
#(
  parameter int DEPTH = 2816,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [15:0]        reqAddr,
  input  logic [SIZE_W-1:0]  sizeField,
  output logic               romEn,
  output logic [AW-1:0]      romAddr,
  output ctrlStrobes_t       strobes
);
  walkState_t        state;
  logic [AW-1:0]     cur;
  logic [15:0]       tgt;
  logic [IDX_W-1:0]  reqIdx;
  logic [SIZE_W-1:0] sizeQ;
  logic              wrPend;
  logic [IDX_W-1:0]  wrIdx;
  logic              errQ;
  logic [16:0]       nxtStart;
  logic              badPkt;
  logic              hit;

  assign nxtStart = 17'(cur) + 17'(sizeField) + 17'd2;
  assign badPkt   = (sizeField == '0) || (nxtStart > 17'(DEPTH));
  assign hit      = !badPkt && ({1'b0, tgt} < nxtStart);

  always_comb begin
    romEn   = 1'b0;
    romAddr = cur;
    if (state == ST_HDR) begin
      romEn = 1'b1;
    end else if (state == ST_PAY) begin
      romEn   = 1'b1;
      romAddr = cur + AW'(reqIdx) + AW'(1);
    end
  end

  assign strobes.busy    = (state != ST_IDLE);
  assign strobes.err     = errQ;
  assign strobes.hdrLoad = (state == ST_CHK) && hit;
  assign strobes.bufWr   = wrPend;
  assign strobes.bufIdx  = wrIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cur    <= '0;
      tgt    <= '0;
      reqIdx <= '0;
      sizeQ  <= '0;
      wrPend <= 1'b0;
      wrIdx  <= '0;
      errQ   <= 1'b0;
    end else begin
      wrPend <= (state == ST_PAY);
      wrIdx  <= reqIdx;
      case (state)
        ST_IDLE: if (startReq) begin
          tgt   <= reqAddr;
          cur   <= '0;
          errQ  <= 1'b0;
          state <= ST_HDR;
        end
        ST_HDR: state <= ST_CHK;
        ST_CHK: begin
          if (badPkt) begin
            errQ  <= 1'b1;
            state <= ST_IDLE;
          end else if (hit) begin
            sizeQ  <= sizeField;
            reqIdx <= '0;
            state  <= ST_PAY;
          end else if (nxtStart == 17'(DEPTH)) begin
            errQ  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cur   <= AW'(nxtStart);
            state <= ST_HDR;
          end
        end
        ST_PAY: begin
          reqIdx <= reqIdx + IDX_W'(1);
          if (reqIdx == IDX_W'(sizeQ)) state <= ST_LAST;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otpPktData.sv
module otpPktData
  import otpPktPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [5:0]   busAddr,
  input  logic         busWe,
  input  logic         busRe,
  input  logic [31:0]  busWdata,
  input  logic [31:0]  romData,
  input  ctrlStrobes_t strobes,
  output logic         startReq,
  output logic [15:0]  reqAddr,
  output logic [31:0]  busRdata
);
  logic [15:0]      modeAddr;
  logic [IDX_W-1:0] rdIdx;
  logic [31:0]      hdrReg;
  logic [31:0]      payBuf [PAY_MAX];
  logic             unusedBits;

  assign unusedBits = ^{busWdata[15:9], strobes.bufIdx[IDX_W-1]};
  assign startReq   = busWe && (busAddr == OFS_CTRL) && busWdata[START_BIT];
  assign reqAddr    = modeAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeAddr <= '0;
      rdIdx    <= '0;
      hdrReg   <= '0;
    end else begin
      if (busWe && busAddr == OFS_MODE) modeAddr <= busWdata[31:16];
      if (busWe && busAddr == OFS_AUX) begin
        rdIdx <= busWdata[IDX_W-1:0];
      end else if (busRe && busAddr == OFS_DATA && rdIdx != '1) begin
        rdIdx <= rdIdx + IDX_W'(1);
      end
      if (strobes.hdrLoad) hdrReg <= romData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.bufWr) payBuf[strobes.bufIdx[SIZE_W-1:0]] <= romData;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_MODE: busRdata = {modeAddr, 16'h0000};
      OFS_AUX:  busRdata = 32'(rdIdx);
      OFS_STAT: begin
        busRdata[BUSY_BIT] = strobes.busy;
        busRdata[ERR_BIT]  = strobes.err;
      end
      OFS_HDR:  busRdata = hdrReg;
      OFS_DATA: if (rdIdx <= IDX_W'(hdrReg[15:8])) busRdata = payBuf[rdIdx[SIZE_W-1:0]];
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/otpPacketReader.sv
module otpPacketReader
  import otpPktPkg::*;
#(
  parameter int DEPTH = 2816,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [5:0]    busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output logic          romEn,
  output logic [AW-1:0] romAddr,
  input  logic [31:0]   romData
);
  ctrlStrobes_t strobes;
  logic         startReq;
  logic [15:0]  reqAddr;
  logic         busyW;
  logic         errW;

  assign busyW = strobes.busy;
  assign errW  = strobes.err;

  otpPktCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqAddr(reqAddr),
    .sizeField(romData[15:8]), .romEn(romEn), .romAddr(romAddr),
    .strobes(strobes)
  );

  otpPktData uData (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .romData(romData),
    .strobes(strobes), .startReq(startReq), .reqAddr(reqAddr),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/otpPacketReaderChk.sv
module otpPacketReaderChk #(
  parameter int DEPTH = 2816,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic [5:0]    busAddr,
  input logic          busWe,
  input logic          startBit,
  input logic          romEn,
  input logic [AW-1:0] romAddr,
  input logic          busy,
  input logic          err
);
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busWe && busAddr == 6'h00 && startBit));

  p_hdr_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (romEn && romAddr == '0));

  p_rom_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    romEn |-> busy);

  p_rom_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    romEn |-> (int'(romAddr) < DEPTH));

  p_err_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !err);
endmodule

bind otpPacketReader otpPacketReaderChk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .startBit(busWdata[6]), .romEn(romEn), .romAddr(romAddr),
  .busy(busyW), .err(errW)
);

// File: tb/tb_otpPacketReader.sv
module tb_otpPacketReader;
  localparam int DEPTH = 2816;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_AUX = 6'h08,
                         A_STAT = 6'h0C, A_HDR = 6'h20, A_DATA = 6'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0]  busAddr = A_STAT;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        romEn;
  logic [AW-1:0] romAddr;
  logic [31:0] romData;
  logic [31:0] rom [DEPTH];

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otpPacketReader #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata),
    .romEn(romEn), .romAddr(romAddr), .romData(romData)
  );

  always_ff @(posedge clk) if (romEn) romData <= rom[romAddr];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = A_STAT;
  endtask

  task automatic readReg(input logic [5:0] a, input bit pop, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRe = pop;
    #1 v = busRdata;
    @(posedge clk);
    #1 busRe = 1'b0;
  endtask

  // Behavioural packet walk taken from R4, R8 and R10
  task automatic walkModel(input int tgt, output int base, output int sz, output int dur, output bit e);
    int cur = 0;
    int h = 0;
    e = 1'b0; base = 0; sz = 0;
    forever begin
      int s;
      int nxt;
      h++;
      s = int'(rom[cur][15:8]);
      nxt = cur + s + 2;
      if (s == 0 || nxt > DEPTH) begin e = 1'b1; break; end
      if (tgt < nxt) begin base = cur; sz = s; break; end
      if (nxt == DEPTH) begin e = 1'b1; break; end
      cur = nxt;
    end
    dur = e ? 2 * h : 2 * h + sz + 2;
  endtask

  task automatic runRead(input int tgt, input bit inject);
    int base, sz, dur;
    bit e;
    logic [31:0] st, v;
    walkModel(tgt, base, sz, dur, e);
    busWrite(A_MODE, 32'(tgt) << 16);
    busWrite(A_CTRL, 32'h40);
    for (int k = 0; k <= dur; k++) begin
      if (k > 0) @(negedge clk);
      busWe = 1'b0; busAddr = A_STAT;
      #1 st = busRdata;
      check(st[6] == (k < dur), "R3/R10/R9 busy window", 32'(st[6]), 32'(k < dur));
      if (inject && k == 1) begin
        busAddr = A_CTRL; busWdata = 32'h40; busWe = 1'b1;
      end
    end
    check(st[0] == e, "R8 error flag", 32'(st[0]), 32'(e));
    if (!e) begin
      readReg(A_HDR, 1'b0, v);
      check(v == rom[base], "R5 enclosing header", v, rom[base]);
      busWrite(A_AUX, 32'h0);
      for (int i = 0; i <= sz; i++) begin
        readReg(A_DATA, 1'b1, v);
        check(v == rom[base + 1 + i], "R6 payload stream", v, rom[base + 1 + i]);
      end
      readReg(A_DATA, 1'b1, v);
      check(v == 32'h0, "R7 read past payload", v, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int sizes [4] = '{3, 1, 20, 255};
    int b = 0;
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) rom[i] = '0;
    for (int p = 0; p < 4; p++) begin
      rom[b] = {8'hA5, 8'(p), 8'(sizes[p]), 8'h3C};
      for (int k = 0; k <= sizes[p]; k++) rom[b + 1 + k] = {8'(p + 1), 8'h00, 16'(k * 7 + 3)};
      b = b + sizes[p] + 2;
    end
    // packets at 0, 5, 8, 30; terminator header (size 0) at 287

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    readReg(A_STAT, 1'b0, v); check(v == 0, "R1 status after reset", v, 0);
    readReg(A_HDR,  1'b0, v); check(v == 0, "R1 header after reset", v, 0);
    readReg(A_MODE, 1'b0, v); check(v == 0, "R1 mode after reset", v, 0);
    readReg(A_AUX,  1'b0, v); check(v == 0, "R1 index after reset", v, 0);

    busWrite(A_MODE, 32'h0007_FFFF);
    readReg(A_MODE, 1'b0, v); check(v == 32'h0007_0000, "R2 mode readback", v, 32'h0007_0000);

    runRead(0, 1'b0);
    runRead(4, 1'b0);
    runRead(5, 1'b0);
    runRead(7, 1'b0);
    runRead(15, 1'b1);   // R9: command injected while busy
    runRead(30, 1'b0);
    runRead(200, 1'b0);
    runRead(286, 1'b0);  // R4: last word of the largest packet
    runRead(287, 1'b0);  // R8: terminator header
    readReg(A_CTRL, 1'b0, v); check(v == 0, "R2 control reads zero", v, 0);
    runRead(8, 1'b0);    // R8: error cleared by next command

    busWrite(A_AUX, 32'h2);
    readReg(A_DATA, 1'b1, v); check(v == rom[11], "R6 indexed start", v, rom[11]);
    readReg(A_AUX, 1'b0, v); check(v == 3, "R6 index advanced", v, 3);
    busWrite(A_AUX, 32'd21);
    readReg(A_DATA, 1'b0, v); check(v == 0, "R7 index beyond size", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule